// File: doc/BRIEF.md
# Serial Port Interrupt Source and Identification Logic

This block is the interrupt source logic of a 16550-style serial port. The rest of the port reports its conditions to it as event inputs: receive data at or above the threshold, receive timeout, transmit holding empty, transmitter fully idle, line status and modem status. The block holds the enable register and the FIFO-enable state. Each event is gated by its enable bit, and the highest-priority survivor is encoded into the identification byte. A single interrupt request line is high whenever any gated event is pending.

Software reaches the block over a simple register bus. The enable register sits at offset 1. Offset 2 is shared: a read returns the identification byte, and a write goes to the FIFO control register, whose bit 0 turns the FIFOs on. The transmit-holding-empty condition is held in a latch. A one-cycle pulse from the transmitter sets it. It is cleared when software reads the identification byte while that condition is the reported source.

An extended-mode input unlocks one further enable: transmitter and transmit FIFO both empty. That event is reported under the transmit code.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset the enable register reads 0x00 at offset 1, the identification byte reads 0x01 at offset 2, and `irq` is low.
- R2: A write at offset 1 stores data bits 3:0 into the enable register. Bit 5 is stored only while `ext_mode` is 1; otherwise it is written as 0. Bits 4, 6 and 7 always read 0.
- R3: A write at offset 2 sets the FIFO-enable state from data bit 0 and leaves the enable register unchanged. Identification bits 7:6 both equal the FIFO-enable state, and bits 5:4 read 0.
- R4: With enable bit 2 set, `ev_line` is reported as identification bits 3:0 = 0110.
- R5: With enable bit 0 set, `ev_rx_level` is reported as 0100. `ev_rx_timeout` alone is reported as 1100, but only while the FIFOs are enabled; with the FIFOs disabled it has no effect. When both receive events are active, 0100 is reported.
- R6: A one-cycle pulse on `ev_thr_set` latches a transmit-holding-empty condition, reported as 0010 when enable bit 1 is set. A read at offset 2 (`bus_rd`) clears the latch only when 0010 from this latch is the reported code. A pulse in the same cycle as a clearing read keeps the latch set.
- R7: With enable bit 5 set and `ext_mode` 1, `ev_tx_idle` is reported as 0010. With `ext_mode` 0 it has no effect.
- R8: With enable bit 3 set, `ev_modem` is reported as 0000.
- R9: Priority from highest to lowest is line status, receive, transmit, modem. Bit 0 of the identification byte is 0 exactly when some source is reported.
- R10: `irq` is high exactly when a gated event is pending, which is the inverse of identification bit 0. An event whose enable bit is clear has no effect on `irq` or on the identification byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_mode | input | 1 | Extended mode select |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (used for read-clear) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| ev_rx_level | input | 1 | Receive FIFO at or above threshold |
| ev_rx_timeout | input | 1 | Receive timeout |
| ev_thr_set | input | 1 | Pulse: transmit holding register became empty |
| ev_tx_idle | input | 1 | Transmitter and transmit FIFO both empty |
| ev_line | input | 1 | Line status event |
| ev_modem | input | 1 | Modem status event |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach from the ports is the read-clear of the transmit latch. A read must clear the latch only when that latch is the reported source. It must not clear the latch when a higher source masks it, and it must lose to a set pulse arriving in the same cycle. The stimulus first raises line status above a latched transmit condition and reads, then confirms the latch survived. It then issues a read and a set pulse in one cycle and reads again to confirm the latch is still set. Timeout masking is reached by turning the FIFOs off through the shared offset while the timeout stays asserted.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
   typedef enum logic [3:0] {
      SRC_MODEM  = 4'b0000,
      SRC_NONE   = 4'b0001,
      SRC_TXRDY  = 4'b0010,
      SRC_RXDATA = 4'b0100,
      SRC_LINE   = 4'b0110,
      SRC_RXTMO  = 4'b1100
   } irq_src_e;

   localparam int EN_RX     = 0;
   localparam int EN_TX     = 1;
   localparam int EN_LS     = 2;
   localparam int EN_MS     = 3;
   localparam int EN_TXIDLE = 5;
endpackage

// File: rtl/uart_irq_regs.sv
module uart_irq_regs #(
   parameter int ADDR_W      = 3,
   parameter int IER_OFFS    = 1,
   parameter int EIR_OFFS    = 2,
   parameter bit EXT_SUPPORT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ext_mode,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic [7:0]        wdata,
   output logic [7:0]        ier_q,
   output logic              fifo_en
);
   localparam logic [ADDR_W-1:0] A_IER = ADDR_W'(IER_OFFS);
   localparam logic [ADDR_W-1:0] A_FCR = ADDR_W'(EIR_OFFS);

   logic [7:0] wmask;

   generate
      if (EXT_SUPPORT) begin : g_ext
         assign wmask = ext_mode ? 8'h2F : 8'h0F;
      end else begin : g_std
         logic unused_ext;
         assign unused_ext = ext_mode;
         assign wmask = 8'h0F;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ier_q   <= 8'h00;
         fifo_en <= 1'b0;
      end else if (wr) begin
         if (addr == A_IER) ier_q   <= wdata & wmask;
         if (addr == A_FCR) fifo_en <= wdata[0];
      end
   end

   // R3: control write captures the FIFO enable
   p_fcr_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && addr == A_FCR) |=> (fifo_en == $past(wdata[0])));
   // R3: control write leaves the enable register alone
   p_ier_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && addr == A_FCR) |=> $stable(ier_q));
endmodule

// File: rtl/uart_irq_txlatch.sv
module uart_irq_txlatch (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic pend
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   pend <= 1'b0;
      else if (set) pend <= 1'b1;
      else if (clr) pend <= 1'b0;
   end

   // R6: a set pulse always leaves the latch set
   p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
      set |=> pend);
   // R6: a clearing read without a set empties the latch
   p_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !set) |=> !pend);
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
   import uart_irq_pkg::*;
(
   input  logic     en_rx,
   input  logic     en_tx,
   input  logic     en_ls,
   input  logic     en_ms,
   input  logic     en_txidle,
   input  logic     fifo_en,
   input  logic     ev_rx_level,
   input  logic     ev_rx_timeout,
   input  logic     tx_pend,
   input  logic     ev_tx_idle,
   input  logic     ev_line,
   input  logic     ev_modem,
   output irq_src_e src,
   output logic     tx_is_src,
   output logic     any
);
   logic g_line, g_rxd, g_rxt, g_txh, g_txi, g_ms;

   assign g_line = ev_line & en_ls;
   assign g_rxd  = ev_rx_level & en_rx;
   assign g_rxt  = ev_rx_timeout & fifo_en & en_rx;
   assign g_txh  = tx_pend & en_tx;
   assign g_txi  = ev_tx_idle & en_txidle;
   assign g_ms   = ev_modem & en_ms;

   assign any = g_line | g_rxd | g_rxt | g_txh | g_txi | g_ms;

   always_comb begin
      tx_is_src = 1'b0;
      if (g_line)               src = SRC_LINE;
      else if (g_rxd)           src = SRC_RXDATA;
      else if (g_rxt)           src = SRC_RXTMO;
      else if (g_txh | g_txi) begin
         src       = SRC_TXRDY;
         tx_is_src = g_txh;
      end
      else if (g_ms)            src = SRC_MODEM;
      else                      src = SRC_NONE;
   end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
   import uart_irq_pkg::*;
#(
   parameter int ADDR_W      = 3,
   parameter int IER_OFFS    = 1,
   parameter int EIR_OFFS    = 2,
   parameter bit EXT_SUPPORT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ext_mode,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic              ev_rx_level,
   input  logic              ev_rx_timeout,
   input  logic              ev_thr_set,
   input  logic              ev_tx_idle,
   input  logic              ev_line,
   input  logic              ev_modem,
   output logic              irq
);
   localparam logic [ADDR_W-1:0] A_IER = ADDR_W'(IER_OFFS);
   localparam logic [ADDR_W-1:0] A_EIR = ADDR_W'(EIR_OFFS);

   generate
      if (IER_OFFS == EIR_OFFS) begin : g_bad_offs
         $error("enable and identification offsets must differ");
      end
      if (IER_OFFS >= (1 << ADDR_W) || EIR_OFFS >= (1 << ADDR_W)) begin : g_bad_width
         $error("register offset does not fit the address width");
      end
   endgenerate

   logic [7:0] ier_q;
   logic       fifo_en;
   logic       tx_pend;
   logic       tx_is_src;
   logic       any_pend;
   logic       ext_eff;
   logic       rd_clear;
   irq_src_e   src;
   logic [7:0] eir_val;

   assign ext_eff = EXT_SUPPORT ? ext_mode : 1'b0;

   uart_irq_regs #(
      .ADDR_W(ADDR_W), .IER_OFFS(IER_OFFS), .EIR_OFFS(EIR_OFFS), .EXT_SUPPORT(EXT_SUPPORT)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .ext_mode(ext_eff), .addr(bus_addr),
      .wr(bus_wr), .wdata(bus_wdata), .ier_q(ier_q), .fifo_en(fifo_en)
   );

   assign rd_clear = bus_rd && (bus_addr == A_EIR) && tx_is_src;

   uart_irq_txlatch u_tx (
      .clk(clk), .rst_n(rst_n), .set(ev_thr_set), .clr(rd_clear), .pend(tx_pend)
   );

   uart_irq_prio u_prio (
      .en_rx(ier_q[EN_RX]), .en_tx(ier_q[EN_TX]), .en_ls(ier_q[EN_LS]),
      .en_ms(ier_q[EN_MS]), .en_txidle(ier_q[EN_TXIDLE] & ext_eff),
      .fifo_en(fifo_en), .ev_rx_level(ev_rx_level), .ev_rx_timeout(ev_rx_timeout),
      .tx_pend(tx_pend), .ev_tx_idle(ev_tx_idle), .ev_line(ev_line),
      .ev_modem(ev_modem), .src(src), .tx_is_src(tx_is_src), .any(any_pend)
   );

   assign eir_val = {fifo_en, fifo_en, 2'b00, src};
   assign irq     = any_pend;

   always_comb begin
      if (bus_addr == A_IER)      bus_rdata = ier_q;
      else if (bus_addr == A_EIR) bus_rdata = eir_val;
      else                        bus_rdata = 8'h00;
   end

   // R10: request line is the inverse of the pending flag
   p_irq_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq != eir_val[0]);
   // R5: timeout code only with FIFOs on
   p_tmo_needs_fifo_r5: assert property (@(posedge clk) disable iff (!rst_n)
      eir_val[3] |-> fifo_en);
   // R9: enabled line status always wins
   p_line_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_line && ier_q[EN_LS]) |-> (eir_val[3:0] == SRC_LINE));
   // R2: reserved enable bits stay clear
   p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ier_q[7:6] == 2'b00) && !ier_q[4]);
endmodule

// File: tb/sim_uart_irq_ident.sv
`timescale 1ns/1ps
module sim_uart_irq_ident;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ext_mode = 1'b0;
   logic [2:0] bus_addr = '0;
   logic       bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       ev_rx_level = 0, ev_rx_timeout = 0, ev_thr_set = 0;
   logic       ev_tx_idle = 0, ev_line = 0, ev_modem = 0;
   logic       irq;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   logic [7:0] q_rd[$];
   logic       q_irq[$];
   string      q_tag[$];

   always #10 clk = ~clk;

   uart_irq_ident u0 (
      .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .bus_addr(bus_addr),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ev_rx_level(ev_rx_level), .ev_rx_timeout(ev_rx_timeout), .ev_thr_set(ev_thr_set),
      .ev_tx_idle(ev_tx_idle), .ev_line(ev_line), .ev_modem(ev_modem), .irq(irq)
   );

   // monitor: compares pending expectations mid-cycle
   always @(negedge clk) begin
      while (q_rd.size() > 0) begin
         logic [7:0] er;
         logic       ei;
         string      t;
         er = q_rd.pop_front();
         ei = q_irq.pop_front();
         t  = q_tag.pop_front();
         n_checks++;
         if (bus_rdata !== er || irq !== ei) begin
            n_fail++;
            $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b", t, bus_rdata, irq, er, ei);
         end
      end
   end

   task automatic step();
      @(posedge clk);
      #2;
   endtask

   task automatic chk(input logic [2:0] a, input logic [7:0] er, input logic ei, input string t);
      bus_addr = a;
      q_rd.push_back(er); q_irq.push_back(ei); q_tag.push_back(t);
      step();
   endtask

   task automatic chk_rd(input logic [2:0] a, input logic [7:0] er, input logic ei, input string t);
      bus_addr = a;
      bus_rd = 1'b1;
      q_rd.push_back(er); q_irq.push_back(ei); q_tag.push_back(t);
      step();
      bus_rd = 1'b0;
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      step();
      bus_wr = 1'b0;
   endtask

   task automatic pulse_thr();
      ev_thr_set = 1'b1;
      step();
      ev_thr_set = 1'b0;
   endtask

   initial begin
      step(); step();
      rst_n = 1'b1;
      step();
      chk(3'd1, 8'h00, 1'b0, "R1 enable reset");
      chk(3'd2, 8'h01, 1'b0, "R1 ident reset");

      wr(3'd1, 8'hFF);
      chk(3'd1, 8'h0F, 1'b0, "R2 normal mode write");
      ext_mode = 1'b1;
      wr(3'd1, 8'hFF);
      chk(3'd1, 8'h2F, 1'b0, "R2 extended mode write");
      wr(3'd1, 8'h00);
      ext_mode = 1'b0;
      chk(3'd1, 8'h00, 1'b0, "R2 clear");

      wr(3'd2, 8'h01);
      chk(3'd2, 8'hC1, 1'b0, "R3 fifo on");
      chk(3'd1, 8'h00, 1'b0, "R3 enable unchanged");
      wr(3'd2, 8'hFE);
      chk(3'd2, 8'h01, 1'b0, "R3 fifo off");
      wr(3'd2, 8'h01);

      ev_line = 1; ev_rx_level = 1; ev_modem = 1; ev_rx_timeout = 1; ev_tx_idle = 1;
      chk(3'd2, 8'hC1, 1'b0, "R10 disabled events ignored");
      ev_rx_timeout = 0; ev_tx_idle = 0;

      wr(3'd1, 8'h0F);
      chk(3'd2, 8'hC6, 1'b1, "R4 line status highest");
      ev_line = 0;
      chk(3'd2, 8'hC4, 1'b1, "R9 receive over modem");
      ev_rx_timeout = 1;
      chk(3'd2, 8'hC4, 1'b1, "R5 level over timeout");
      ev_rx_level = 0;
      chk(3'd2, 8'hCC, 1'b1, "R5 timeout code");
      wr(3'd2, 8'h00);
      chk(3'd2, 8'h00, 1'b1, "R5 timeout ignored fifo off");
      ev_modem = 0;
      chk(3'd2, 8'h01, 1'b0, "R5 timeout alone fifo off");
      wr(3'd2, 8'h01);
      chk(3'd2, 8'hCC, 1'b1, "R5 timeout fifo on again");
      ev_rx_timeout = 0; ev_modem = 1;
      chk(3'd2, 8'hC0, 1'b1, "R8 modem code");

      pulse_thr();
      chk(3'd2, 8'hC2, 1'b1, "R6 transmit over modem");
      chk_rd(3'd2, 8'hC2, 1'b1, "R6 clearing read");
      chk(3'd2, 8'hC0, 1'b1, "R6 latch cleared");

      pulse_thr();
      ev_line = 1;
      chk_rd(3'd2, 8'hC6, 1'b1, "R6 read while masked");
      ev_line = 0;
      chk(3'd2, 8'hC2, 1'b1, "R6 latch kept when masked");

      ev_thr_set = 1'b1;
      chk_rd(3'd2, 8'hC2, 1'b1, "R6 read with set");
      ev_thr_set = 1'b0;
      chk(3'd2, 8'hC2, 1'b1, "R6 set wins over clear");
      chk_rd(3'd2, 8'hC2, 1'b1, "R6 second clearing read");
      chk(3'd2, 8'hC0, 1'b1, "R6 cleared again");

      ev_modem = 0; ev_tx_idle = 1;
      wr(3'd1, 8'h2F);
      chk(3'd1, 8'h0F, 1'b0, "R7 bit5 dropped normal mode");
      chk(3'd2, 8'hC1, 1'b0, "R7 idle ignored normal mode");
      ext_mode = 1'b1;
      wr(3'd1, 8'h2F);
      chk(3'd2, 8'hC2, 1'b1, "R7 idle reported extended");
      ext_mode = 1'b0;
      chk(3'd2, 8'hC1, 1'b0, "R7 idle gated on mode exit");
      ev_tx_idle = 0;

      step();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end
endmodule